// File: doc/BRIEF.md
# DDR2 Power-Up Initialisation Sequencer

This block takes a DDR2 memory subsystem from reset to a usable state without software involvement. Once reset is released it programs the PHY delay-locked loop in two writes (enable, then start), waits for the PHY to report lock on both of its lock indications, and then lets the memory clock run for a power-up interval. It then plays a fixed script of thirteen commands into the memory controller's command port. After every command it waits for the controller's busy flag to drop, and after selected commands it also inserts a settling gap.

CAS latency and write recovery arrive as static configuration inputs and are folded into the mode-register command words. The clock frequency is a parameter, and every wait is derived from it as a cycle count. A done flag rises after the final command completes and stays high until the next reset.

The state machine has these states: `ST_IDLE` (reset state), `ST_DLL_ON` and `ST_DLL_START` (the two PHY writes), `ST_LOCK_WAIT`, `ST_PWRUP`, `ST_ISSUE` (command strobe), `ST_SETTLE` (one cycle in which busy is ignored), `ST_BUSY`, `ST_GAP` and `ST_DONE`. The transitions are:
- `ST_IDLE` to `ST_DLL_ON` to `ST_DLL_START` to `ST_LOCK_WAIT`, one cycle each.
- `ST_LOCK_WAIT` to `ST_PWRUP` once both lock bits are high.
- `ST_PWRUP` to `ST_ISSUE` when the power-up timer expires.
- `ST_ISSUE` to `ST_SETTLE` to `ST_BUSY`.
- `ST_BUSY` moves on when busy is low: to `ST_DONE` after the last step, to `ST_ISSUE` for the next step when no gap is due, or to `ST_GAP` when a gap is due.
- `ST_GAP` to `ST_ISSUE` for the next step when the gap timer expires.
- `ST_DONE` holds.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst_n` is low, `phy_cfg_valid`, `cmd_valid` and `done` are all low.
- R2: Exactly two PHY configuration strobes occur, in consecutive cycles, starting in the second cycle after reset release. The first word is 0x0002_2828 and the second is 0x0003_2828. Bits [7:0] hold the DLL start point 0x28, bits [15:8] hold the increment 0x28, bit 17 is DLL enable and bit 16 is DLL start.
- R3: `phy_lock` is examined only after the second PHY write, and the sequence advances only in a cycle where both `phy_lock` bits are high. A single lock bit never advances it.
- R4: The first command strobe comes exactly PWRUP_US×CLK_MHZ+1 cycles after the first cycle in which lock is examined and both bits are high.
- R5: Thirteen commands are strobed in this order: wake-up 0x1000_0000, NOP 0x2000_0000, precharge-all 0x3000_0000, EMR2 0x8040_0000, EMR3 0x8050_0000, EMR1, mode register with DLL reset, precharge-all, auto-refresh 0x4000_0000, auto-refresh, mode register, EMR1 with OCD default, EMR1 with OCD exit.
- R6: The mode-register word is 0x8020_0003 + CAS×16 + (write recovery−1)×512, plus 0x100 for the DLL-reset variant. This gives burst length 8. CAS ranges 3..6 and write recovery ranges 2..8.
- R7: The EMR1 word is 0x8030_0006, meaning ODT 75 Ω (payload bit 2), reduced drive (bit 1) and DLL enabled (bit 0 clear). OCD default sets payload bits [9:7], giving 0x8030_0386. OCD exit adds no bits, giving 0x8030_0006.
- R8: Each command strobe lasts one cycle, and `cmd_busy` is ignored in the cycle after it. Let b be the first later cycle in which busy is sampled low. With no gap due, the next strobe comes in cycle b+1.
- R9: After EMR1, the DLL-reset mode write, the second precharge-all and the final mode write, the next strobe comes in cycle b+GAP_US×CLK_MHZ+1.
- R10: After each auto-refresh, the next strobe comes in cycle b+max(REF_MIN_CYC, GAP_US×CLK_MHZ)+1.
- R11: `done` rises in cycle b+1 after the final command and then stays high with no further strobe until reset. A fresh reset restarts the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cas_lat | input | 3 | CAS latency in clocks, static |
| wr_rec | input | 4 | Write recovery in clocks, static |
| phy_lock | input | 2 | PHY DLL lock indications |
| phy_cfg_valid | output | 1 | PHY configuration write strobe |
| phy_cfg_word | output | 32 | PHY configuration word |
| cmd_valid | output | 1 | Command strobe to the controller |
| cmd_word | output | 32 | Command code |
| cmd_busy | input | 1 | Controller busy flag |
| done | output | 1 | Initialisation complete |

## Verification
The hardest cases to reach are the edges of the busy handshake and the lock gate. One is a controller that never raises busy, where the sequencer must still skip the settle cycle. Another is a PHY that reports only one lock bit for a long stretch. A third is a lock that is already present before the PHY writes. Separate runs force each of these: busy held low throughout, busy held high for six cycles, one lock bit held for 300 cycles, and lock held during reset. These sit alongside runs with random lock delay, busy length and timing fields. Every strobe is timed against the cycle in which the bench's own busy model went low.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DLL_ON,
        ST_DLL_START,
        ST_LOCK_WAIT,
        ST_PWRUP,
        ST_ISSUE,
        ST_SETTLE,
        ST_BUSY,
        ST_GAP,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        GAP_NONE,
        GAP_US,
        GAP_REF
    } gap_kind_t;

    localparam int unsigned NUM_STEPS = 13;

    // PHY DLL programming fields
    localparam logic [7:0] DLL_POINT   = 8'h28;
    localparam logic [7:0] DLL_STEP    = 8'h28;
    localparam int unsigned DLL_EN_BIT = 17;
    localparam int unsigned DLL_GO_BIT = 16;

    // command opcodes, bits [31:28]
    localparam logic [3:0] OP_WAKE    = 4'h1;
    localparam logic [3:0] OP_NOP     = 4'h2;
    localparam logic [3:0] OP_PREALL  = 4'h3;
    localparam logic [3:0] OP_REFRESH = 4'h4;
    localparam logic [3:0] OP_LOADREG = 4'h8;

    // load-register targets, bits [23:20]
    localparam logic [3:0] TGT_MR   = 4'h2;
    localparam logic [3:0] TGT_EMR1 = 4'h3;
    localparam logic [3:0] TGT_EMR2 = 4'h4;
    localparam logic [3:0] TGT_EMR3 = 4'h5;

    // register payload bits
    localparam logic [15:0] MR_BURST8    = 16'h0003;
    localparam logic [15:0] MR_DLL_RESET = 16'h0100;
    localparam logic [15:0] EMR1_ODT75   = 16'h0004;
    localparam logic [15:0] EMR1_WEAKDRV = 16'h0002;
    localparam logic [15:0] EMR1_DLL_EN  = 16'h0000;
    localparam logic [15:0] EMR1_OCD_DEF = 16'h0380;
    localparam logic [15:0] EMR1_OCD_EXT = 16'h0000;

    function automatic logic [31:0] plain_cmd(input logic [3:0] op);
        return {op, 28'h0};
    endfunction

    function automatic logic [31:0] load_cmd(input logic [3:0] tgt, input logic [15:0] pay);
        return {OP_LOADREG, 4'h0, tgt, 4'h0, pay};
    endfunction

    function automatic logic [31:0] phy_word(input logic go);
        logic [31:0] w;
        w = {16'h0, DLL_STEP, DLL_POINT};
        w[DLL_EN_BIT] = 1'b1;
        w[DLL_GO_BIT] = go;
        return w;
    endfunction

endpackage

// File: rtl/ddr2_wait_timer.sv
module ddr2_wait_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // a wait counts down one per cycle (R4, R9, R10)
    p_tick_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // a load takes the requested length (R9)
    p_load_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/ddr2_cmd_builder.sv
module ddr2_cmd_builder
    import ddr2_init_pkg::*;
#(
    parameter int unsigned STEP_W = 4
) (
    input  logic [STEP_W-1:0] step,
    input  logic [2:0]        cas_lat,
    input  logic [3:0]        wr_rec,
    output logic [31:0]       word,
    output gap_kind_t         gap,
    output logic              last
);

    logic [3:0]  wr_less1;
    logic [15:0] mr_pay;
    logic [15:0] emr1_pay;

    always_comb begin
        wr_less1 = wr_rec - 4'd1;
        mr_pay   = MR_BURST8 | {9'h0, cas_lat, 4'h0} | {4'h0, wr_less1[2:0], 9'h0};
        emr1_pay = EMR1_ODT75 | EMR1_WEAKDRV | EMR1_DLL_EN;
    end

    always_comb begin
        word = plain_cmd(OP_NOP);
        gap  = GAP_NONE;
        last = 1'b0;
        case (step)
            4'd0:  word = plain_cmd(OP_WAKE);
            4'd1:  word = plain_cmd(OP_NOP);
            4'd2:  word = plain_cmd(OP_PREALL);
            4'd3:  word = load_cmd(TGT_EMR2, 16'h0);
            4'd4:  word = load_cmd(TGT_EMR3, 16'h0);
            4'd5:  begin word = load_cmd(TGT_EMR1, emr1_pay);              gap = GAP_US;  end
            4'd6:  begin word = load_cmd(TGT_MR, mr_pay | MR_DLL_RESET);   gap = GAP_US;  end
            4'd7:  begin word = plain_cmd(OP_PREALL);                      gap = GAP_US;  end
            4'd8:  begin word = plain_cmd(OP_REFRESH);                     gap = GAP_REF; end
            4'd9:  begin word = plain_cmd(OP_REFRESH);                     gap = GAP_REF; end
            4'd10: begin word = load_cmd(TGT_MR, mr_pay);                  gap = GAP_US;  end
            4'd11: word = load_cmd(TGT_EMR1, emr1_pay | EMR1_OCD_DEF);
            4'd12: begin word = load_cmd(TGT_EMR1, emr1_pay | EMR1_OCD_EXT); last = 1'b1; end
            default: begin word = plain_cmd(OP_NOP); last = 1'b1; end
        endcase
    end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 400,
    parameter int unsigned PWRUP_US    = 200,
    parameter int unsigned GAP_US      = 1,
    parameter int unsigned REF_MIN_CYC = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  cas_lat,
    input  logic [3:0]  wr_rec,
    input  logic [1:0]  phy_lock,
    output logic        phy_cfg_valid,
    output logic [31:0] phy_cfg_word,
    output logic        cmd_valid,
    output logic [31:0] cmd_word,
    input  logic        cmd_busy,
    output logic        done
);

    localparam int unsigned PWRUP_CYC = PWRUP_US * CLK_MHZ;
    localparam int unsigned US_CYC    = GAP_US * CLK_MHZ;
    localparam int unsigned REF_CYC   = (REF_MIN_CYC > US_CYC) ? REF_MIN_CYC : US_CYC;
    localparam int unsigned MAX_CYC   = (PWRUP_CYC > REF_CYC) ? PWRUP_CYC : REF_CYC;
    localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);
    localparam int unsigned STEP_W    = $clog2(NUM_STEPS);
    localparam logic [CNT_W-1:0] PWRUP_LOAD = CNT_W'(PWRUP_CYC - 1);
    localparam logic [CNT_W-1:0] US_LOAD    = CNT_W'(US_CYC - 1);
    localparam logic [CNT_W-1:0] REF_LOAD   = CNT_W'(REF_CYC - 1);

    seq_state_t        state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic [31:0]       step_word;
    gap_kind_t         step_gap;
    logic              step_last;
    logic              both_locked;

    assign both_locked = &phy_lock;

    ddr2_cmd_builder #(.STEP_W(STEP_W)) u_builder (
        .step    (step_q),
        .cas_lat (cas_lat),
        .wr_rec  (wr_rec),
        .word    (step_word),
        .gap     (step_gap),
        .last    (step_last)
    );

    ddr2_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // next state and timer control
    always_comb begin
        state_d  = state_q;
        step_d   = step_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE:      state_d = ST_DLL_ON;
            ST_DLL_ON:    state_d = ST_DLL_START;
            ST_DLL_START: state_d = ST_LOCK_WAIT;
            ST_LOCK_WAIT: begin
                if (both_locked) begin
                    state_d  = ST_PWRUP;
                    tmr_load = 1'b1;
                    tmr_val  = PWRUP_LOAD;
                end
            end
            ST_PWRUP: begin
                if (tmr_expired) state_d = ST_ISSUE;
            end
            ST_ISSUE:     state_d = ST_SETTLE;
            ST_SETTLE:    state_d = ST_BUSY;
            ST_BUSY: begin
                if (!cmd_busy) begin
                    if (step_last) begin
                        state_d = ST_DONE;
                    end else if (step_gap == GAP_NONE) begin
                        state_d = ST_ISSUE;
                        step_d  = step_q + 1'b1;
                    end else begin
                        state_d  = ST_GAP;
                        tmr_load = 1'b1;
                        tmr_val  = (step_gap == GAP_REF) ? REF_LOAD : US_LOAD;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    state_d = ST_ISSUE;
                    step_d  = step_q + 1'b1;
                end
            end
            ST_DONE:      state_d = ST_DONE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        phy_cfg_valid = 1'b0;
        phy_cfg_word  = '0;
        cmd_valid     = 1'b0;
        cmd_word      = '0;
        done          = 1'b0;
        unique case (state_q)
            ST_DLL_ON: begin
                phy_cfg_valid = 1'b1;
                phy_cfg_word  = phy_word(1'b0);
            end
            ST_DLL_START: begin
                phy_cfg_valid = 1'b1;
                phy_cfg_word  = phy_word(1'b1);
            end
            ST_ISSUE: begin
                cmd_valid = 1'b1;
                cmd_word  = step_word;
            end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    // the DLL start write follows the enable write directly (R2)
    p_phy_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_cfg_valid && !phy_cfg_word[DLL_GO_BIT]) |=> (phy_cfg_valid && phy_cfg_word[DLL_GO_BIT]));

    // without both lock bits the lock wait holds (R3)
    p_lock_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK_WAIT && !both_locked) |=> (state_q == ST_LOCK_WAIT && !cmd_valid));

    // strobe is one cycle, then a cycle in which busy is not looked at (R8)
    p_cmd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (!cmd_valid ##1 !cmd_valid));

    // busy high holds the next command back (R8)
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && cmd_busy) |=> (!cmd_valid && !done));

    // no strobe during a running gap (R10)
    p_gap_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && !tmr_expired) |=> !cmd_valid);

    // done is sticky and silent (R11)
    p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !cmd_valid && !phy_cfg_valid));

    // reset keeps every output quiet (R1)
    always_comb begin
        if (!rst_n && state_q == ST_IDLE) begin
            a_reset_quiet_r1: assert (!phy_cfg_valid && !cmd_valid && !done);
        end
    end

endmodule

// File: tb/tb_ddr2_init_seq.sv
module tb_ddr2_init_seq;

    localparam int MHZ   = 4;
    localparam int PWRUS = 200;
    localparam int GUS   = 1;
    localparam int REFMIN = 8;
    localparam int PWR_C = PWRUS * MHZ;
    localparam int US_C  = GUS * MHZ;
    localparam int REF_C = (REFMIN > US_C) ? REFMIN : US_C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cas_lat = 3'd3;
    logic [3:0]  wr_rec = 4'd2;
    logic [1:0]  phy_lock = 2'b00;
    logic        phy_cfg_valid;
    logic [31:0] phy_cfg_word;
    logic        cmd_valid;
    logic [31:0] cmd_word;
    logic        cmd_busy = 1'b0;
    logic        done;

    always #2 clk = ~clk;

    ddr2_init_seq #(.CLK_MHZ(MHZ), .PWRUP_US(PWRUS), .GAP_US(GUS), .REF_MIN_CYC(REFMIN)) dut (
        .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .wr_rec(wr_rec),
        .phy_lock(phy_lock), .phy_cfg_valid(phy_cfg_valid), .phy_cfg_word(phy_cfg_word),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_busy(cmd_busy), .done(done)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errors = 0;
    int checks = 0;

    int          cmd_cyc [0:31];
    logic [31:0] cmd_w   [0:31];
    int          busy_lo [0:31];
    int          cmd_n;
    int          phy_cyc [0:7];
    logic [31:0] phy_w   [0:7];
    int          phy_n;
    int          done_cyc;
    int          busy_mode = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int s, input int cl, input int wr);
        logic [31:0] mr;
        mr = 32'h8020_0003 + 32'(cl * 16) + 32'((wr - 1) * 512);
        case (s)
            0: return 32'h1000_0000;
            1: return 32'h2000_0000;
            2: return 32'h3000_0000;
            3: return 32'h8040_0000;
            4: return 32'h8050_0000;
            5: return 32'h8030_0006;
            6: return mr + 32'h100;
            7: return 32'h3000_0000;
            8: return 32'h4000_0000;
            9: return 32'h4000_0000;
            10: return mr;
            11: return 32'h8030_0386;
            default: return 32'h8030_0006;
        endcase
    endfunction

    function automatic int exp_gap(input int s);
        if (s == 8 || s == 9) return REF_C;
        if (s == 5 || s == 6 || s == 7 || s == 10) return US_C;
        return 0;
    endfunction

    // controller and PHY-write observer
    initial begin
        int rem;
        int n;
        rem = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                cmd_n = 0; phy_n = 0; done_cyc = -1; rem = 0; cmd_busy = 1'b0;
            end else begin
                if (phy_cfg_valid && phy_n < 8) begin
                    phy_cyc[phy_n] = cyc; phy_w[phy_n] = phy_cfg_word; phy_n++;
                end
                if (done && done_cyc < 0) done_cyc = cyc;
                if (cmd_valid) begin
                    if (busy_mode == 1) n = 0;
                    else if (busy_mode == 2) n = 6;
                    else n = int'($urandom % 5);
                    if (cmd_n < 32) begin
                        cmd_cyc[cmd_n] = cyc;
                        cmd_w[cmd_n]   = cmd_word;
                        busy_lo[cmd_n] = cyc + 1 + ((n > 1) ? n : 1);
                        cmd_n++;
                    end
                    rem = n;
                    cmd_busy = 1'b0;
                end else if (rem > 0) begin
                    cmd_busy = 1'b1;
                    rem--;
                end else begin
                    cmd_busy = 1'b0;
                end
            end
        end
    end

    task automatic run(input int mode, input int cl, input int wr);
        int rel, lock_at, lk, waited, exp_first;
        string tag;
        rst_n = 1'b0;
        cas_lat = 3'(cl);
        wr_rec = 4'(wr);
        busy_mode = (mode == 2) ? 1 : (mode == 3) ? 2 : 0;
        phy_lock = (mode == 0) ? 2'b11 : 2'b00;
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        check(!phy_cfg_valid && !cmd_valid && !done, "R1 reset outputs",
              {phy_cfg_valid, cmd_valid, done}, 0);
        rst_n = 1'b1;
        rel = cyc;
        lock_at = 0;
        if (mode != 0) begin
            repeat (1 + int'($urandom % 40)) @(negedge clk);
            if (mode == 1) begin
                phy_lock = 2'b01;
                repeat (300) @(negedge clk);
                phy_lock = 2'b10;
                repeat (20) @(negedge clk);
            end
            phy_lock = 2'b11;
            lock_at = cyc;
        end
        waited = 0;
        while (!done && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1, "R11 done reached", done, 1);
        repeat (30) @(negedge clk);

        // R2
        check(phy_n == 2, "R2 phy write count", phy_n, 2);
        check(phy_w[0] == 32'h0002_2828, "R2 dll enable word", phy_w[0], 32'h0002_2828);
        check(phy_w[1] == 32'h0003_2828, "R2 dll start word", phy_w[1], 32'h0003_2828);
        check(phy_cyc[0] == rel + 1, "R2 first write cycle", phy_cyc[0], rel + 1);
        check(phy_cyc[1] == phy_cyc[0] + 1, "R2 back-to-back", phy_cyc[1], phy_cyc[0] + 1);

        // R3, R4
        lk = (lock_at > phy_cyc[1] + 1) ? lock_at : phy_cyc[1] + 1;
        exp_first = lk + PWR_C + 1;
        check(cmd_n >= 1 && cmd_cyc[0] == exp_first, "R3 R4 wake-up timing", cmd_cyc[0], exp_first);

        // R5, R6, R7
        check(cmd_n == 13, "R5 command count", cmd_n, 13);
        for (int s = 0; s < 13; s++) begin
            if (s == 6 || s == 10) tag = "R6 mode word";
            else if (s == 5 || s == 11 || s == 12) tag = "R7 emr1 word";
            else tag = "R5 command word";
            check(cmd_w[s] == exp_word(s, cl, wr), tag, cmd_w[s], exp_word(s, cl, wr));
        end

        // R8, R9, R10
        for (int s = 0; s < 12; s++) begin
            if (exp_gap(s) == 0) tag = "R8 busy spacing";
            else if (s == 8 || s == 9) tag = "R10 refresh gap";
            else tag = "R9 microsecond gap";
            check(cmd_cyc[s + 1] == busy_lo[s] + 1 + exp_gap(s), tag,
                  cmd_cyc[s + 1], busy_lo[s] + 1 + exp_gap(s));
        end

        // R11
        check(done_cyc == busy_lo[12] + 1, "R11 done timing", done_cyc, busy_lo[12] + 1);
        check(done == 1'b1 && cmd_n == 13, "R11 done held, no more commands", cmd_n, 13);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run(0, 3, 2);
        run(1, 6, 8);
        run(2, 5, 4);
        run(3, 4, 6);
        for (int r = 0; r < 3; r++) begin
            run(4, 3 + int'($urandom % 4), 2 + int'($urandom % 7));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R11 watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule